// File: doc/BRIEF.md
# Reset Cause Register with Software Reset Request

This block keeps a record of why the system last came out of reset and lets software ask for a new system reset. It holds a five-bit cause field in the top of a 32-bit word. Some of these bits are cleared by writing 1 to them. The others are sticky request bits that a written 1 sets and a written 0 leaves alone. A saturating reset counter tells the first reset after power-up apart from every later one. Only that first reset loads the power-on flag.

Software reaches the register through one 32-bit access port. The register occupies an 8-byte window. Only the word with address bit 2 set is live. The other word reads as zero and drops writes. Writing the software power-on bit pulses the reset request output and re-arms power-on detection, so the next system reset loads the power-on flag again. Writing the software external-reset bit also pulses the request, but leaves the counter alone. A separate cold power-up input clears both the register and the counter.

Top module: `rst_cause_reg`

## Requirements
- R1: While `cold_rst_n` is low and just after it rises, `rst_req` is 0 and the live word reads 0x00000000.
- R2: A `warm_rst` cycle while the reset counter is zero (after cold power-up or after a software power-on request) loads the register with 0x80000000, so only bit 31 (power-on) is set.
- R3: A `warm_rst` cycle while the counter is nonzero leaves the register value unchanged.
- R4: Bits 31, 28 and 27 clear when 1 is written to them. Writing 0 to them leaves them unchanged, and no write can set them.
- R5: Bit 30 (software power-on) and bit 29 (software external reset) become 1 when 1 is written. Writing 0 to them leaves them unchanged.
- R6: Bits 26 to 0 of the live word always read 0.
- R7: A live write with bit 30 set makes `rst_req` high for exactly the one cycle after the write edge and zeroes the counter.
- R8: A live write with bit 29 set and bit 30 clear makes `rst_req` high for one cycle and leaves the counter unchanged.
- R9: Accesses to the low word of the window (address bit 2 clear), or to any address outside the window starting at `WIN_BASE`, read 0 and change no state.
- R10: The reset counter saturates at its maximum. After any number of `warm_rst` cycles, the register is not reloaded unless software re-arms it.
- R11: When `warm_rst` and a write occur in the same cycle, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold power-up clear, active low |
| warm_rst | input | 1 | System reset event, one clocked cycle per reset |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | ADDR_W | Byte address of the access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational from address and register |
| rst_req | output | 1 | Registered one-cycle system reset request |

## Verification
Read data depends combinationally on the address and the register, so a write becomes visible in the half cycle after its clock edge. The request pulse is registered at the same edge as the write. It is high in the half cycle after the write edge and low again one cycle later. The bench drives every input on the falling edge and samples on the next falling edge, so each check falls at the exact cycle its result is due. The pulse is checked at both its high and low points.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              rst_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [4:0] W1C_M = 5'b10011;
  localparam logic [4:0] SET_M = 5'b01100;

  logic [4:0]       cause;
  logic [CNT_W-1:0] rcnt;
  logic             hit, live, wr;
  logic [4:0]       wv;

  assign hit  = cfg_addr[ADDR_W-1:3] == WIN_BASE[ADDR_W-1:3];
  assign live = hit & cfg_addr[2];
  assign wr   = cfg_we & live & ~warm_rst;
  assign wv   = cfg_wdata[31:27];
  assign cfg_rdata = live ? {cause, 27'd0} : 32'd0;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      cause   <= '0;
      rcnt    <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wr & (wv[3] | wv[2]);
      if (warm_rst) begin
        if (rcnt == '0) cause <= 5'b10000;
        if (rcnt != CNT_MAX) rcnt <= rcnt + 1'b1;
      end else if (wr) begin
        cause <= (cause & ~(wv & W1C_M)) | (wv & SET_M);
        if (wv[3]) rcnt <= '0;
      end
    end
  end

  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rst_req |-> $past(cfg_we)); // R7
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst && rcnt == '0) |=> cause == 5'b10000); // R2
  AST_LATER_KEEP: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst && rcnt != '0) |=> $stable(cause)); // R3
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst && rcnt == CNT_MAX) |=> rcnt == CNT_MAX); // R10
  AST_SOFT_POR_REARM: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (cfg_we && live && !warm_rst && cfg_wdata[30]) |=> (rcnt == '0 && rst_req)); // R7
  AST_LOW_WORD_IGNORED: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst && !live) |=> ($stable(cause) && $stable(rcnt))); // R9
  AST_NO_SET_W1C: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst) |=> ((cause & W1C_M) & ~$past(cause & W1C_M)) == 5'b0); // R4
endmodule

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = 16'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        rst_req;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] LIVE = 16'hF024;
  localparam logic [15:0] LOW  = 16'hF020;

  always #10 clk = ~clk;

  rst_cause_reg u0 (.clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rst_req(rst_req));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    cfg_addr = a;
    #1 v = cfg_rdata;
    cfg_addr = LIVE;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, bit with_warm = 0);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1; warm_rst = with_warm;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; warm_rst = 1'b0; cfg_addr = LIVE;
  endtask

  task automatic pulse_reset();
    warm_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    warm_rst = 1'b0;
  endtask

  task automatic cold();
    cold_rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    cold_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    cold();
    rd(LIVE, v);
    check("R1 live word after cold", v, 32'h0);
    check("R1 rst_req after cold", {31'd0, rst_req}, 32'd0);
  endtask

  task automatic t_first_and_later();
    logic [31:0] v;
    pulse_reset();
    rd(LIVE, v);
    check("R2 first reset loads power-on", v, 32'h8000_0000);
    check("R6 low bits zero", v & 32'h07FF_FFFF, 32'h0);
    wr(LIVE, 32'h2000_0000);
    check("R8 pulse high", {31'd0, rst_req}, 32'd1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'd0, rst_req}, 32'd0);
    rd(LIVE, v);
    check("R5 bit29 set", v, 32'hA000_0000);
    pulse_reset();
    rd(LIVE, v);
    check("R3 later reset keeps value", v, 32'hA000_0000);
    check("R8 counter not cleared by bit29", v, 32'hA000_0000);
  endtask

  task automatic t_w1c_and_sticky();
    logic [31:0] v;
    wr(LIVE, 32'h0000_0000);
    rd(LIVE, v);
    check("R4 R5 zero write keeps", v, 32'hA000_0000);
    check("R5 zero write no pulse", {31'd0, rst_req}, 32'd0);
    wr(LIVE, 32'h9800_0000);
    rd(LIVE, v);
    check("R4 w1c clears bit31, cannot set 28/27", v, 32'h2000_0000);
    wr(LIVE, 32'h07FF_FFFF);
    rd(LIVE, v);
    check("R6 low write bits dropped", v, 32'h2000_0000);
  endtask

  task automatic t_window();
    logic [31:0] v;
    rd(LOW, v);
    check("R9 low word reads 0", v, 32'h0);
    wr(LOW, 32'h4000_0000);
    check("R9 low word write no pulse", {31'd0, rst_req}, 32'd0);
    rd(LIVE, v);
    check("R9 low word write ignored", v, 32'h2000_0000);
    wr(16'hE024, 32'h4000_0000);
    check("R9 outside window no pulse", {31'd0, rst_req}, 32'd0);
    rd(16'hE024, v);
    check("R9 outside window reads 0", v, 32'h0);
    rd(LIVE, v);
    check("R9 outside write ignored", v, 32'h2000_0000);
  endtask

  task automatic t_soft_por();
    logic [31:0] v;
    wr(LIVE, 32'h2000_0000);
    wr(LIVE, 32'h4000_0000);
    check("R7 pulse high", {31'd0, rst_req}, 32'd1);
    rd(LIVE, v);
    check("R7 bit30 set", v, 32'h6000_0000);
    @(negedge clk);
    check("R7 pulse one cycle", {31'd0, rst_req}, 32'd0);
    pulse_reset();
    rd(LIVE, v);
    check("R7 R2 rearmed reload", v, 32'h8000_0000);
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    wr(LIVE, 32'h8000_0000);
    for (int i = 0; i < 40; i++) pulse_reset();
    rd(LIVE, v);
    check("R10 counter saturates no reload", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(LIVE, 32'h2000_0000, 1'b1);
    check("R11 collide no pulse", {31'd0, rst_req}, 32'd0);
    rd(LIVE, v);
    check("R11 collide write dropped", v, 32'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_first_and_later();
    t_w1c_and_sticky();
    t_window();
    t_soft_por();
    t_saturate();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule